// File: doc/BRIEF.md
# Windowed Load/Store Queue Issue Throttle

This block keeps the memory operations of an out-of-order core in a circular queue. Operations enter in program order at the tail and leave in order from the head. A smaller sliding issue window opens at the head and covers the oldest entries. Only an entry inside this window may go to memory. Younger entries wait outside it even when their operands are ready. Because the window size can be changed while the core runs, the amount of memory reordering can be throttled without changing the queue's capacity.

Each cycle the block reports the oldest in-window entry whose ready line is set, and that entry is marked as issued. The memory pipeline signals completion through one input. When the head entry has issued and completion is raised, the head entry retires and the window slides forward by one place. Once the queue holds as many entries as it has slots, a stall goes back to rename and further allocation requests are dropped. A flush input clears the whole queue.

Entry state encoding, two bits per entry on `state_vec` (entry i at bits 2i+1:2i): 0 = empty, 1 = waiting inside the window, 2 = waiting outside the window (blocked), 3 = issued.

Top module: `lsq_window_throttle`

## Requirements
- R1: After reset every entry reads 0 (empty), `rename_stall` is low, `issue_valid` is low and `alloc_idx` is 0.
- R2: `alloc_valid` without a stall writes a new entry at slot `alloc_idx` in the next cycle. `alloc_idx` then steps by one, wrapping from DEPTH-1 to 0.
- R3: `rename_stall` is high exactly while DEPTH entries are occupied. An allocation request during a stall leaves every entry and `alloc_idx` unchanged.
- R4: A waiting entry whose age offset from the head is below the window size reads 1. A waiting entry at a larger offset reads 2 and is never issued, whatever its ready line says.
- R5: `win_sel` values 0 to 5 give a window of 2, 4, 8, 16, 32 or 64 entries. Values 6 and 7 give 64. The result is capped at DEPTH, and a change shows in the entry states one cycle later.
- R6: In the same cycle, `issue_valid` goes high for the entry that reads 1, has its `ready_vec` bit set, and is nearest the head. `issue_idx` names that entry. At most one entry issues per cycle.
- R7: An issued entry reads 3 from the next cycle until it retires.
- R8: `complete` while the head entry reads 3 empties that entry in the next cycle and advances the head by one. In any other cycle `complete` has no effect.
- R9: `flush` empties every entry and returns `alloc_idx` and the head to slot 0 in the next cycle. In a flush cycle `issue_valid` is low, and allocation, issue and retire are all dropped.
- R10: When the head advances, the window moves with it, so blocked entries that fall inside the new window read 1 in the same next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Clear the whole queue |
| win_sel | input | 3 | Issue window size code |
| alloc_valid | input | 1 | Rename offers a new memory operation |
| ready_vec | input | DEPTH | Per-entry operand ready |
| complete | input | 1 | Head memory operation finished |
| rename_stall | output | 1 | Queue full, stall rename |
| alloc_idx | output | log2(DEPTH) | Slot the next allocation will use |
| issue_valid | output | 1 | An entry is issued this cycle |
| issue_idx | output | log2(DEPTH) | Slot being issued |
| state_vec | output | 2*DEPTH | Two-bit state of every entry |

## Verification
Three events can fall in the same cycle: retiring the head, allocating at the tail and issuing a third entry. A retire in one cycle also reclassifies every waiting entry against the moved window before the next cycle. The bench runs long stretches with allocation, completion and random ready lines all active together, under every window code, including a full queue that retires and allocates in one cycle. It also flushes in cycles where all three events are pending. A behavioural queue model predicts stall, issue choice, allocation slot and every entry's state each cycle, and the bench compares all of them.

// File: rtl/lsqw_pkg.sv
package lsqw_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_NOTRDY  = 2'd1,
        ST_BLOCKED = 2'd2,
        ST_ISSUED  = 2'd3
    } ent_state_e;

    localparam int unsigned WIN_SEL_W = 3;
    localparam int unsigned WIN_MAX   = 64;

    typedef struct packed {
        logic flush;
        logic alloc;
        logic issue;
        logic retire;
    } lsq_events_t;

    // window size in entries for a selector code, never above the queue depth
    function automatic int unsigned win_entries(input logic [WIN_SEL_W-1:0] sel,
                                                input int unsigned depth);
        int unsigned w;
        w = (sel > 3'd5) ? WIN_MAX : (32'd2 << sel);
        return (w > depth) ? depth : w;
    endfunction

endpackage

// File: rtl/lsqw_ptrs.sv
module lsqw_ptrs #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] head_idx,
    output logic [IDX_W-1:0] tail_idx,
    output logic             full
);

    // pointers carry one extra wrap bit to separate full from empty
    logic [CNT_W-1:0] head_q;
    logic [CNT_W-1:0] tail_q;
    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head_q <= '0;
            tail_q <= '0;
        end else begin
            if (push) tail_q <= tail_q + 1'b1;
            if (pop)  head_q <= head_q + 1'b1;
        end
    end

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign count    = tail_q - head_q;
    assign full     = (head_q[IDX_W] != tail_q[IDX_W]) && (head_idx == tail_idx);

    // R3
    count_cap_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R8
    head_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !flush) |=> (head_q == $past(head_q) + 1'b1));

    // R9
    flush_zero_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (head_q == '0 && tail_q == '0));

endmodule

// File: rtl/lsqw_window.sv
module lsqw_window
    import lsqw_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = IDX_W + 1
) (
    input  logic [WIN_SEL_W-1:0] win_sel,
    input  logic [IDX_W-1:0]     base_idx,
    output logic [DEPTH-1:0]     in_win
);

    logic [CNT_W-1:0] wsz;

    assign wsz = CNT_W'(win_entries(win_sel, DEPTH));

    // age offset from the head decides window membership
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [IDX_W-1:0] off;
        assign off       = IDX_W'(i) - base_idx;
        assign in_win[i] = ({1'b0, off} < wsz);
    end

endmodule

// File: rtl/lsqw_picker.sv
module lsqw_picker #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] cand,
    input  logic [IDX_W-1:0] base_idx,
    output logic             found,
    output logic [IDX_W-1:0] pick
);

    logic [IDX_W-1:0] idx;

    // scan youngest to oldest so the oldest candidate wins last
    always_comb begin
        found = 1'b0;
        pick  = '0;
        idx   = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = base_idx + IDX_W'(k);
            if (cand[idx]) begin
                found = 1'b1;
                pick  = idx;
            end
        end
    end

endmodule

// File: rtl/lsq_window_throttle.sv
module lsq_window_throttle
    import lsqw_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SV_W  = 2 * DEPTH
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [WIN_SEL_W-1:0] win_sel,
    input  logic                 alloc_valid,
    input  logic [DEPTH-1:0]     ready_vec,
    input  logic                 complete,
    output logic                 rename_stall,
    output logic [IDX_W-1:0]     alloc_idx,
    output logic                 issue_valid,
    output logic [IDX_W-1:0]     issue_idx,
    output logic [SV_W-1:0]      state_vec
);

    ent_state_e       state_q [DEPTH];
    ent_state_e       state_d [DEPTH];
    lsq_events_t      ev;
    logic             full;
    logic [IDX_W-1:0] head_idx;
    logic [IDX_W-1:0] tail_idx;
    logic [IDX_W-1:0] head_nxt;
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] in_win_n;
    logic             found;
    logic [IDX_W-1:0] pick;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cand
        assign cand[i] = (state_q[i] == ST_NOTRDY) && ready_vec[i];
        assign state_vec[2*i +: 2] = state_q[i];
    end

    lsqw_picker #(.DEPTH(DEPTH)) i_picker (
        .cand     (cand),
        .base_idx (head_idx),
        .found    (found),
        .pick     (pick)
    );

    always_comb begin
        ev.flush  = flush;
        ev.alloc  = alloc_valid && !full && !flush;
        ev.retire = complete && (state_q[head_idx] == ST_ISSUED) && !flush;
        ev.issue  = found && !flush;
    end

    lsqw_ptrs #(.DEPTH(DEPTH)) i_ptrs (
        .clk      (clk),
        .rst      (rst),
        .flush    (ev.flush),
        .push     (ev.alloc),
        .pop      (ev.retire),
        .head_idx (head_idx),
        .tail_idx (tail_idx),
        .full     (full)
    );

    // the window opens at the head the queue will have next cycle
    assign head_nxt = head_idx + IDX_W'(ev.retire);

    lsqw_window #(.DEPTH(DEPTH)) i_window (
        .win_sel  (win_sel),
        .base_idx (head_nxt),
        .in_win   (in_win_n)
    );

    always_comb begin
        ent_state_e s;
        for (int i = 0; i < DEPTH; i++) begin
            s = state_q[i];
            if (ev.issue  && pick     == IDX_W'(i)) s = ST_ISSUED;
            if (ev.retire && head_idx == IDX_W'(i)) s = ST_EMPTY;
            if (ev.alloc  && tail_idx == IDX_W'(i)) s = ST_NOTRDY;
            if (s == ST_NOTRDY || s == ST_BLOCKED)
                s = in_win_n[i] ? ST_NOTRDY : ST_BLOCKED;
            state_d[i] = s;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (rst || ev.flush) state_q[i] <= ST_EMPTY;
            else                 state_q[i] <= state_d[i];
        end
    end

    assign rename_stall = full;
    assign alloc_idx    = tail_idx;
    assign issue_valid  = ev.issue;
    assign issue_idx    = pick;

    // R6
    issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |-> (ready_vec[issue_idx] && state_q[issue_idx] == ST_NOTRDY));

    // R7
    issue_mark_chk: assert property (@(posedge clk) disable iff (rst)
        issue_valid |=> (state_q[$past(issue_idx)] == ST_ISSUED));

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rename_stall && alloc_valid && !flush) |=> (alloc_idx == $past(alloc_idx)));

    // R9
    flush_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> !issue_valid);

    // R8
    retire_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (complete && !flush && state_q[head_idx] == ST_ISSUED)
            |=> (state_q[$past(head_idx)] == ST_EMPTY));

endmodule

// File: tb/test_lsq_window_throttle.sv
module test_lsq_window_throttle;

    localparam int DEPTH = 16;
    localparam int IDX_W = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             flush = 1'b0;
    logic [2:0]       win_sel = 3'd0;
    logic             alloc_valid = 1'b0;
    logic [DEPTH-1:0] ready_vec = '0;
    logic             complete = 1'b0;
    logic             rename_stall;
    logic [IDX_W-1:0] alloc_idx;
    logic             issue_valid;
    logic [IDX_W-1:0] issue_idx;
    logic [2*DEPTH-1:0] state_vec;

    int n_cmp = 0;
    int n_bad = 0;
    int m_st [DEPTH];
    int m_hd = 0;
    int m_tl = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    lsq_window_throttle #(.DEPTH(DEPTH)) i_lsq_window_throttle (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .win_sel      (win_sel),
        .alloc_valid  (alloc_valid),
        .ready_vec    (ready_vec),
        .complete     (complete),
        .rename_stall (rename_stall),
        .alloc_idx    (alloc_idx),
        .issue_valid  (issue_valid),
        .issue_idx    (issue_idx),
        .state_vec    (state_vec)
    );

    task automatic check_int(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog (R1..all) actual=timeout expected=finished");
        summary();
        $finish;
    end

    // one clock of stimulus: compare against model, advance model, cross the edge
    task automatic step();
        bit found;
        bit ret;
        bit alc;
        int pk;
        int wsz;
        int off;
        #1;
        found = 0;
        pk = 0;
        for (int k = 0; k < DEPTH; k++) begin
            int idx;
            idx = (m_hd + k) % DEPTH;
            if (!found && m_st[idx] == 1 && ready_vec[idx]) begin
                found = 1;
                pk = idx;
            end
        end
        if (flush) found = 0;
        check_int("R3 rename_stall", int'(rename_stall), int'(m_cnt == DEPTH));
        check_int("R6 R4 issue_valid", int'(issue_valid), int'(found));
        if (found) check_int("R6 issue_idx", int'(issue_idx), pk);
        check_int("R2 alloc_idx", int'(alloc_idx), m_tl);
        for (int i = 0; i < DEPTH; i++)
            check_int($sformatf("R4 R7 R8 R10 state of entry %0d", i),
                      int'(state_vec[2*i +: 2]), m_st[i]);
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
            m_hd = 0; m_tl = 0; m_cnt = 0;
        end else begin
            ret = complete && (m_st[m_hd] == 3);
            alc = alloc_valid && (m_cnt != DEPTH);
            if (found) m_st[pk] = 3;
            if (ret) begin
                m_st[m_hd] = 0;
                m_hd = (m_hd + 1) % DEPTH;
                m_cnt--;
            end
            if (alc) begin
                m_st[m_tl] = 1;
                m_tl = (m_tl + 1) % DEPTH;
                m_cnt++;
            end
            wsz = (win_sel > 5) ? 64 : (2 << win_sel);
            if (wsz > DEPTH) wsz = DEPTH;
            for (int i = 0; i < DEPTH; i++) begin
                off = (i - m_hd + DEPTH) % DEPTH;
                if (m_st[i] == 1 || m_st[i] == 2) m_st[i] = (off < wsz) ? 1 : 2;
            end
        end
        @(posedge clk);
        #1;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        #1;
        check_int("R1 stall after reset", int'(rename_stall), 0);
        check_int("R1 issue after reset", int'(issue_valid), 0);
        check_int("R1 alloc_idx after reset", int'(alloc_idx), 0);
        check_int("R1 all entries empty", int'(state_vec), 0);

        // R2 R3 R4: fill with a window of 2, nothing ready, then push while full
        win_sel = 3'd0;
        alloc_valid = 1'b1;
        for (int c = 0; c < DEPTH + 3; c++) step();
        alloc_valid = 1'b0;
        check_int("R3 stall when full", int'(rename_stall), 1);

        // R4: blocked entries stay put even when ready
        ready_vec = '1;
        for (int c = 0; c < 3; c++) step();

        // R8 R10: retire slides the window, complete ignored when head not issued
        complete = 1'b1;
        for (int c = 0; c < 8; c++) step();
        complete = 1'b0;
        ready_vec = '0;

        // R5: each window code under mixed traffic, including depth-sized windows
        for (int s = 0; s < 8; s++) begin
            win_sel = 3'(s);
            for (int c = 0; c < 400; c++) begin
                alloc_valid = ($urandom % 10) < 6;
                complete    = ($urandom % 10) < 4;
                ready_vec   = 16'($urandom);
                flush       = ($urandom % 64) == 0;
                if (c % 50 == 25) win_sel = 3'($urandom % 8);
                step();
            end
            flush = 1'b0;
        end

        // R9: flush with allocation, issue and completion all pending
        win_sel = 3'd3;
        ready_vec = '0;
        alloc_valid = 1'b1;
        for (int c = 0; c < 10; c++) step();
        ready_vec = '1;
        complete = 1'b1;
        flush = 1'b1;
        step();
        flush = 1'b0;
        alloc_valid = 1'b0;
        complete = 1'b0;
        check_int("R9 entries empty after flush", int'(state_vec), 0);
        check_int("R9 alloc_idx zero after flush", int'(alloc_idx), 0);
        for (int c = 0; c < 4; c++) step();

        summary();
        $finish;
    end

endmodule